// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block watches every linear memory access of a processor core and raises a debug-exception request when an access falls on an armed breakpoint. It keeps four breakpoint address registers, one control register and one status register. Each breakpoint carries its own length and access-type qualifier and has separate global and local enables. The status register records every cause of an exception until software clears it.

Software reaches the registers through a small register port. Each access passes a privilege check. An access from protected mode at a nonzero privilege level is refused. An armed guard bit turns any other register access into a debug fault, and that bit clears itself when the exception handler starts. Task-switch, single-step and handler-entry events come in as single-cycle strobes. The exception request `dbgReq` is a one-cycle pulse in the cycle after its cause.

Register selects: 0 to 3 are the breakpoint addresses, 4 is control, 5 is status, and 6 and 7 are unused. Control layout: bits 3:0 are the global enables, bits 7:4 the local enables, bit 8 global exact, bit 9 local exact and bit 10 the guard. For breakpoint i, bits 16+4i..17+4i hold the qualifier and bits 18+4i..19+4i hold the length. Status layout: bits 3:0 are breakpoint hits, bit 8 guard fault, bit 9 single step and bit 10 task trap.

Top module: `brkMatchUnit`

## Requirements
- R1: Selects 0 to 3 write and read the four 32-bit breakpoint addresses. Read data appears on `regRdata` in the cycle after an accepted read and is zero otherwise. Selects 6 and 7 ignore writes and read as zero.
- R2: The data length codes are 00 = 1 byte, 01 = 2 bytes and 1x = 4 bytes. The breakpoint address is aligned down to its length. A data access of `accSize` bytes (same coding) starting at `accAddr` hits when any of its bytes overlaps the breakpoint range.
- R3: An instruction fetch (`accKind` 00) matches only qualifier 00, and only at exactly the breakpoint address, whatever the length field holds.
- R4: Qualifier 01 matches data writes (`accKind` 01). Qualifier 11 matches data reads (`accKind` 10) or writes. Qualifier 10 never matches, and `accKind` 11 matches nothing.
- R5: Breakpoint i is armed when control bit i or bit 4+i is set. A disarmed breakpoint neither requests an exception nor sets its status bit.
- R6: `taskSwitch` clears control bits 7:4 and 9 and keeps all other control bits. When `taskTrap` is high in the same cycle, it sets status bit 10 and requests an exception.
- R7: A register access with `protMode` high and `cplLevel` nonzero pulses `regDenied` in the next cycle and changes nothing. In real mode, any privilege level is allowed.
- R8: While control bit 10 is set, a privileged register access does nothing except set status bit 8 and request an exception. `handlerEntry` clears control bit 10.
- R9: `singleStep` sets status bit 9 and requests an exception.
- R10: Status bits are sticky. Only a write to select 5 replaces them, and events in the same cycle are ORed on top of the written value.
- R11: When a control write coincides with `taskSwitch` or `handlerEntry`, the hardware clear takes effect over the written bits.
- R12: Reset zeroes all registers and outputs. `dbgReq` pulses in the cycle after any cause, and a hit on breakpoint i sets status bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regReq | input | 1 | Register access request |
| regWe | input | 1 | 1 = write, 0 = read |
| regSel | input | 3 | Register select |
| regWdata | input | 32 | Write data |
| protMode | input | 1 | Processor is in protected mode |
| cplLevel | input | 2 | Current privilege level |
| regRdata | output | 32 | Read data, one cycle after request |
| regDenied | output | 1 | Privilege refusal pulse |
| accValid | input | 1 | Observed access valid |
| accAddr | input | 32 | Linear address of access |
| accSize | input | 2 | Access size code |
| accKind | input | 2 | 00 fetch, 01 write, 10 read |
| taskSwitch | input | 1 | Task switch event |
| taskTrap | input | 1 | Incoming task has its trap flag set |
| singleStep | input | 1 | Single-step trap event |
| handlerEntry | input | 1 | Debug handler entered |
| dbgReq | output | 1 | Debug exception request pulse |

## Verification
The hardest states to reach from the ports are the collisions between events: a control write in the same cycle as a task switch or handler entry, and a register access while the guard is armed. With the guard armed, the only way to inspect the register state afterwards is to fire the handler-entry strobe first. The stimulus therefore arms the guard, attempts a write, enters the handler, and then reads back both the untouched address register and the guard-fault status bit. The overlap cases are driven with accesses that straddle the aligned breakpoint range from below, from inside and just past its end.

// File: rtl/brkPkg.sv
package brkPkg;
  localparam int BP_NUM  = 4;
  localparam int SEL_W   = 3;
  localparam int REG_W   = 32;

  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd4;
  localparam logic [SEL_W-1:0] SEL_STAT = 3'd5;

  localparam int C_GEN_LSB   = 0;
  localparam int C_LOC_LSB   = 4;
  localparam int C_GEXACT    = 8;
  localparam int C_LEXACT    = 9;
  localparam int C_GUARD     = 10;
  localparam int C_FIELD_LSB = 16;

  localparam int S_BD = 8;
  localparam int S_BS = 9;
  localparam int S_BT = 10;

  localparam logic [REG_W-1:0] CTRL_MASK =
    REG_W'((((64'd1 << (4 * BP_NUM)) - 64'd1) << C_FIELD_LSB) | ((64'd1 << (C_GUARD + 1)) - 64'd1));
  localparam logic [REG_W-1:0] STAT_MASK =
    REG_W'(((64'd1 << BP_NUM) - 64'd1) | (64'd7 << S_BD));

  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_READ  = 2'b10,
    KIND_NONE  = 2'b11
  } accKind_e;

  typedef struct packed {
    logic [BP_NUM-1:0] wrAddr;
    logic              wrCtrl;
    logic              wrStat;
    logic              rdEn;
    logic              guardTrip;
  } regStrobe_t;
endpackage

// File: rtl/brkControl.sv
module brkControl
  import brkPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regReq,
  input  logic             regWe,
  input  logic [SEL_W-1:0] regSel,
  input  logic             protMode,
  input  logic [1:0]       cplLevel,
  input  logic             guardBit,
  output regStrobe_t       strobe,
  output logic             regDenied
);
  logic privBad;
  logic accepted;

  assign privBad  = protMode && (cplLevel != 2'd0);
  assign accepted = regReq && !privBad && !guardBit;

  always_comb begin
    strobe = '0;
    for (int i = 0; i < BP_NUM; i++) begin
      strobe.wrAddr[i] = accepted && regWe && (regSel == SEL_W'(i));
    end
    strobe.wrCtrl    = accepted && regWe && (regSel == SEL_CTRL);
    strobe.wrStat    = accepted && regWe && (regSel == SEL_STAT);
    strobe.rdEn      = accepted && !regWe;
    strobe.guardTrip = regReq && !privBad && guardBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regDenied <= 1'b0;
    else       regDenied <= regReq && privBad;
  end
endmodule

// File: rtl/brkComparator.sv
module brkComparator
  import brkPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] bpAddr,
  input  logic [1:0]        qual,
  input  logic [1:0]        len,
  input  logic              enable,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [1:0]        accSize,
  input  logic [1:0]        accKind,
  output logic              hit
);
  localparam int EXT_W = ADDR_W + 1;

  logic              isFetch;
  logic [2:0]        bpBytes;
  logic [2:0]        accBytes;
  logic [ADDR_W-1:0] lowMask;
  logic [ADDR_W-1:0] bpLo;
  logic [EXT_W-1:0]  bpEnd;
  logic [EXT_W-1:0]  accEnd;
  logic              overlap;
  logic              qualOk;

  function automatic logic [2:0] sizeBytes(input logic [1:0] code);
    if (code[1])      return 3'd4;
    else if (code[0]) return 3'd2;
    else              return 3'd1;
  endfunction

  always_comb begin
    isFetch  = (accKind == KIND_FETCH);
    bpBytes  = isFetch ? 3'd1 : sizeBytes(len);
    accBytes = isFetch ? 3'd1 : sizeBytes(accSize);
    lowMask  = ADDR_W'(bpBytes) - ADDR_W'(1);
    bpLo     = bpAddr & ~lowMask;
    bpEnd    = {1'b0, bpLo} + EXT_W'(bpBytes);
    accEnd   = {1'b0, accAddr} + EXT_W'(accBytes);
    overlap  = ({1'b0, accAddr} < bpEnd) && ({1'b0, bpLo} < accEnd);
    unique case (qual)
      2'b00:   qualOk = (accKind == KIND_FETCH);
      2'b01:   qualOk = (accKind == KIND_WRITE);
      2'b11:   qualOk = (accKind == KIND_WRITE) || (accKind == KIND_READ);
      default: qualOk = 1'b0;
    endcase
    hit = enable && accValid && qualOk && overlap;
  end
endmodule

// File: rtl/brkDatapath.sv
module brkDatapath
  import brkPkg::*;
#(
  parameter int ADDR_W = REG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [REG_W-1:0]  regWdata,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [1:0]        accSize,
  input  logic [1:0]        accKind,
  input  logic              taskSwitch,
  input  logic              taskTrap,
  input  logic              singleStep,
  input  logic              handlerEntry,
  output logic [REG_W-1:0]  regRdata,
  output logic              dbgReq,
  output logic [REG_W-1:0]  ctrlVal,
  output logic [REG_W-1:0]  statVal,
  output logic              guardBit
);
  logic [ADDR_W-1:0] bpAddr [BP_NUM];
  logic [REG_W-1:0]  ctrlQ, ctrlNext;
  logic [REG_W-1:0]  statQ, statNext;
  logic [REG_W-1:0]  rdMux;
  logic [BP_NUM-1:0] hitVec;
  logic              taskHit;
  logic              anyCause;

  for (genvar i = 0; i < BP_NUM; i++) begin : g_cmp
    brkComparator #(.ADDR_W(ADDR_W)) u_cmp (
      .bpAddr  (bpAddr[i]),
      .qual    (ctrlQ[C_FIELD_LSB + 4*i +: 2]),
      .len     (ctrlQ[C_FIELD_LSB + 4*i + 2 +: 2]),
      .enable  (ctrlQ[C_GEN_LSB + i] | ctrlQ[C_LOC_LSB + i]),
      .accValid(accValid),
      .accAddr (accAddr),
      .accSize (accSize),
      .accKind (accKind),
      .hit     (hitVec[i])
    );
  end

  assign taskHit  = taskSwitch && taskTrap;
  assign anyCause = (|hitVec) || strobe.guardTrip || singleStep || taskHit;

  always_comb begin
    ctrlNext = ctrlQ;
    if (strobe.wrCtrl) ctrlNext = regWdata & CTRL_MASK;
    if (taskSwitch) begin
      ctrlNext[C_LOC_LSB +: BP_NUM] = '0;
      ctrlNext[C_LEXACT]            = 1'b0;
    end
    if (handlerEntry) ctrlNext[C_GUARD] = 1'b0;
  end

  always_comb begin
    statNext = strobe.wrStat ? (regWdata & STAT_MASK) : statQ;
    statNext[BP_NUM-1:0] = statNext[BP_NUM-1:0] | hitVec;
    statNext[S_BD] = statNext[S_BD] | strobe.guardTrip;
    statNext[S_BS] = statNext[S_BS] | singleStep;
    statNext[S_BT] = statNext[S_BT] | taskHit;
  end

  always_comb begin
    rdMux = '0;
    for (int i = 0; i < BP_NUM; i++) begin
      if (regSel == SEL_W'(i)) rdMux = REG_W'(bpAddr[i]);
    end
    if (regSel == SEL_CTRL) rdMux = ctrlQ;
    if (regSel == SEL_STAT) rdMux = statQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BP_NUM; i++) bpAddr[i] <= '0;
      ctrlQ    <= '0;
      statQ    <= '0;
      regRdata <= '0;
      dbgReq   <= 1'b0;
    end else begin
      for (int i = 0; i < BP_NUM; i++) begin
        if (strobe.wrAddr[i]) bpAddr[i] <= ADDR_W'(regWdata);
      end
      ctrlQ    <= ctrlNext;
      statQ    <= statNext;
      regRdata <= strobe.rdEn ? rdMux : '0;
      dbgReq   <= anyCause;
    end
  end

  assign ctrlVal  = ctrlQ;
  assign statVal  = statQ;
  assign guardBit = ctrlQ[C_GUARD];
endmodule

// File: rtl/brkMatchUnit.sv
module brkMatchUnit
  import brkPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regReq,
  input  logic             regWe,
  input  logic [SEL_W-1:0] regSel,
  input  logic [REG_W-1:0] regWdata,
  input  logic             protMode,
  input  logic [1:0]       cplLevel,
  output logic [REG_W-1:0] regRdata,
  output logic             regDenied,
  input  logic             accValid,
  input  logic [REG_W-1:0] accAddr,
  input  logic [1:0]       accSize,
  input  logic [1:0]       accKind,
  input  logic             taskSwitch,
  input  logic             taskTrap,
  input  logic             singleStep,
  input  logic             handlerEntry,
  output logic             dbgReq
);
  regStrobe_t       strobe;
  logic             guardBit;
  logic [REG_W-1:0] ctrlVal;
  logic [REG_W-1:0] statVal;

  brkControl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .regReq   (regReq),
    .regWe    (regWe),
    .regSel   (regSel),
    .protMode (protMode),
    .cplLevel (cplLevel),
    .guardBit (guardBit),
    .strobe   (strobe),
    .regDenied(regDenied)
  );

  brkDatapath #(.ADDR_W(REG_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .regSel      (regSel),
    .regWdata    (regWdata),
    .accValid    (accValid),
    .accAddr     (accAddr),
    .accSize     (accSize),
    .accKind     (accKind),
    .taskSwitch  (taskSwitch),
    .taskTrap    (taskTrap),
    .singleStep  (singleStep),
    .handlerEntry(handlerEntry),
    .regRdata    (regRdata),
    .dbgReq      (dbgReq),
    .ctrlVal     (ctrlVal),
    .statVal     (statVal),
    .guardBit    (guardBit)
  );
endmodule

// File: rtl/brkChecker.sv
module brkChecker
  import brkPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             regReq,
  input logic             regWe,
  input logic             protMode,
  input logic [1:0]       cplLevel,
  input logic             singleStep,
  input logic             taskSwitch,
  input logic             handlerEntry,
  input logic             regDenied,
  input logic             dbgReq,
  input logic [REG_W-1:0] ctrlVal,
  input logic [REG_W-1:0] statVal
);
  logic privBad;
  assign privBad = protMode && (cplLevel != 2'd0);

  a_r7_denied: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && privBad) |=> regDenied);

  a_r7_allowed: assert property (@(posedge clk) disable iff (!rstN)
    !(regReq && privBad) |=> !regDenied);

  a_r9_step: assert property (@(posedge clk) disable iff (!rstN)
    singleStep |=> (dbgReq && statVal[S_BS]));

  a_r6_local_clear: assert property (@(posedge clk) disable iff (!rstN)
    taskSwitch |=> ((ctrlVal[C_LOC_LSB +: BP_NUM] == '0) && !ctrlVal[C_LEXACT]));

  a_r8_guard_clear: assert property (@(posedge clk) disable iff (!rstN)
    handlerEntry |=> !ctrlVal[C_GUARD]);

  a_r8_guard_trip: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !privBad && ctrlVal[C_GUARD]) |=> (dbgReq && statVal[S_BD]));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !(regReq && regWe) |=> ((statVal & $past(statVal)) == $past(statVal)));
endmodule

bind brkMatchUnit brkChecker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .regReq      (regReq),
  .regWe       (regWe),
  .protMode    (protMode),
  .cplLevel    (cplLevel),
  .singleStep  (singleStep),
  .taskSwitch  (taskSwitch),
  .handlerEntry(handlerEntry),
  .regDenied   (regDenied),
  .dbgReq      (dbgReq),
  .ctrlVal     (ctrlVal),
  .statVal     (statVal)
);

// File: tb/sim_brkMatchUnit.sv
`timescale 1ns/1ps
module sim_brkMatchUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regReq = 0, regWe = 0;
  logic [2:0]  regSel = 0;
  logic [31:0] regWdata = 0;
  logic        protMode = 0;
  logic [1:0]  cplLevel = 0;
  logic [31:0] regRdata;
  logic        regDenied;
  logic        accValid = 0;
  logic [31:0] accAddr = 0;
  logic [1:0]  accSize = 0, accKind = 0;
  logic        taskSwitch = 0, taskTrap = 0, singleStep = 0, handlerEntry = 0;
  logic        dbgReq;

  int total = 0;
  int bad = 0;
  string curTag = "R12";

  bit [31:0] mAddr [4];
  bit [31:0] mCtrl, mStat, eRd;
  bit        eDbg, eDen;

  always #2 clk = ~clk;

  brkMatchUnit u0 (.*);

  function automatic longint unsigned nBytes(bit [1:0] c);
    return c[1] ? 4 : (c[0] ? 2 : 1);
  endfunction

  function automatic bit modelHit(int i);
    bit [1:0] q = mCtrl[16 + 4*i +: 2];
    bit [1:0] l = mCtrl[18 + 4*i +: 2];
    longint unsigned n, lo, a;
    if (!accValid || !(mCtrl[i] || mCtrl[4 + i])) return 0;
    a = accAddr;
    if (accKind == 2'b00) return (q == 2'b00) && (accAddr == mAddr[i]);
    if (!((q == 2'b01 && accKind == 2'b01) || (q == 2'b11 && (accKind == 2'b01 || accKind == 2'b10))))
      return 0;
    n  = nBytes(l);
    lo = mAddr[i] & ~(n - 1);
    return (a < lo + n) && (lo < a + nBytes(accSize));
  endfunction

  task automatic modelStep();
    bit allowed = !(protMode && cplLevel != 0);
    bit trip    = regReq && allowed && mCtrl[10];
    bit ok      = regReq && allowed && !mCtrl[10];
    bit [31:0] nc = mCtrl;
    bit [31:0] ns = mStat;
    bit anyHit = 0;
    eDen = regReq && !allowed;
    eRd  = 0;
    if (ok && !regWe) begin
      if (regSel < 4) eRd = mAddr[regSel];
      else if (regSel == 4) eRd = mCtrl;
      else if (regSel == 5) eRd = mStat;
    end
    for (int i = 0; i < 4; i++) if (modelHit(i)) begin ns[i] = 1; anyHit = 1; end
    if (ok && regWe && regSel == 4) nc = regWdata & 32'hFFFF_07FF;
    if (ok && regWe && regSel == 5) ns = (regWdata & 32'h0000_070F) | (ns & 32'hF & ~mStat);
    if (trip) ns[8] = 1;
    if (singleStep) ns[9] = 1;
    if (taskSwitch && taskTrap) ns[10] = 1;
    if (taskSwitch) begin nc[7:4] = 0; nc[9] = 0; end
    if (handlerEntry) nc[10] = 0;
    if (ok && regWe && regSel < 4) mAddr[regSel] = regWdata;
    eDbg  = anyHit || trip || singleStep || (taskSwitch && taskTrap);
    mCtrl = nc;
    mStat = ns;
  endtask

  task automatic tick();
    modelStep();
    @(posedge clk);
    #1;
    total++;
    if (dbgReq !== eDbg || regDenied !== eDen || regRdata !== eRd) begin
      bad++;
      $display("FAIL %s model: dbgReq=%0b/%0b regDenied=%0b/%0b regRdata=%h/%h",
               curTag, dbgReq, eDbg, regDenied, eDen, regRdata, eRd);
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    regReq = 0; regWe = 0; regSel = 0; regWdata = 0;
    accValid = 0; accAddr = 0; accSize = 0; accKind = 0;
    taskSwitch = 0; taskTrap = 0; singleStep = 0; handlerEntry = 0;
  endtask

  task automatic regWrite(bit [2:0] sel, bit [31:0] d);
    regReq = 1; regWe = 1; regSel = sel; regWdata = d;
    tick(); idle();
  endtask

  task automatic regRead(bit [2:0] sel, bit [31:0] exp, string tag);
    regReq = 1; regWe = 0; regSel = sel;
    tick(); idle();
    chk(tag, regRdata, exp);
  endtask

  task automatic access(bit [31:0] a, bit [1:0] sz, bit [1:0] kd, bit exp, string tag);
    accValid = 1; accAddr = a; accSize = sz; accKind = kd;
    tick(); idle();
    chk(tag, {31'b0, dbgReq}, {31'b0, exp});
  endtask

  initial begin
    #(4 * 20000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) mAddr[i] = 0;
    mCtrl = 0; mStat = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    curTag = "R12";
    chk("R12 reset dbgReq", {31'b0, dbgReq}, 0);
    regRead(4, 32'h0, "R12 reset control");
    regRead(5, 32'h0, "R12 reset status");

    curTag = "R1";
    regWrite(1, 32'hCAFE_0010);
    regRead(1, 32'hCAFE_0010, "R1 address readback");
    regWrite(6, 32'h1234_5678);
    regRead(6, 32'h0, "R1 unused select");

    curTag = "R2";
    regWrite(0, 32'h0000_1002);
    regWrite(4, 32'h000F_0001);
    access(32'h1003, 2'b00, 2'b10, 1, "R2 inside 4-byte range");
    access(32'h1004, 2'b00, 2'b10, 0, "R2 past range end");
    access(32'h0FFF, 2'b01, 2'b10, 1, "R2 straddle from below");
    access(32'h0FFE, 2'b01, 2'b10, 0, "R2 just below range");
    regWrite(4, 32'h0007_0001);
    access(32'h1001, 2'b00, 2'b10, 0, "R2 below 2-byte range");
    access(32'h1003, 2'b00, 2'b10, 1, "R2 in 2-byte range");

    curTag = "R3";
    regWrite(1, 32'h0000_2000);
    regWrite(4, 32'h00C0_0002);
    access(32'h2000, 2'b00, 2'b00, 1, "R3 fetch exact");
    access(32'h2001, 2'b11, 2'b00, 0, "R3 fetch length ignored");
    access(32'h2000, 2'b00, 2'b10, 0, "R3 read vs fetch qualifier");

    curTag = "R4";
    regWrite(2, 32'h0000_3000);
    regWrite(4, 32'h0100_0004);
    access(32'h3000, 2'b00, 2'b10, 0, "R4 write qual ignores read");
    access(32'h3000, 2'b00, 2'b01, 1, "R4 write qual hit");
    regWrite(4, 32'h0300_0004);
    access(32'h3000, 2'b00, 2'b10, 1, "R4 rw qual read");
    access(32'h3000, 2'b00, 2'b11, 0, "R4 kind 11 never");
    regWrite(4, 32'h0200_0004);
    access(32'h3000, 2'b00, 2'b01, 0, "R4 qual 10 never");

    curTag = "R5";
    regWrite(3, 32'h0000_4000);
    regWrite(4, 32'h3000_0000);
    access(32'h4000, 2'b00, 2'b01, 0, "R5 disarmed");
    regWrite(4, 32'h3000_0080);
    access(32'h4000, 2'b00, 2'b01, 1, "R5 local enable");

    curTag = "R10";
    regRead(5, 32'h0000_000F, "R10 sticky hit bits");
    regWrite(5, 32'h0);
    regRead(5, 32'h0, "R10 status write clears");

    curTag = "R6";
    regWrite(4, 32'h0000_03FF);
    taskSwitch = 1; tick(); idle();
    chk("R6 switch without trap", {31'b0, dbgReq}, 0);
    regRead(4, 32'h0000_010F, "R6 local bits cleared");
    taskSwitch = 1; taskTrap = 1; tick(); idle();
    chk("R6 trap request", {31'b0, dbgReq}, 1);
    regRead(5, 32'h0000_0400, "R6 task trap status");

    curTag = "R11";
    regReq = 1; regWe = 1; regSel = 4; regWdata = 32'h0000_02F0; taskSwitch = 1;
    tick(); idle();
    regRead(4, 32'h0, "R11 switch beats write");
    regReq = 1; regWe = 1; regSel = 4; regWdata = 32'h0000_0400; handlerEntry = 1;
    tick(); idle();
    regRead(4, 32'h0, "R11 handler beats write");

    curTag = "R7";
    protMode = 1; cplLevel = 3;
    regWrite(0, 32'h0000_5555);
    chk("R7 denied pulse", {31'b0, regDenied}, 1);
    protMode = 1; cplLevel = 0;
    regRead(0, 32'h0000_1002, "R7 denied write had no effect");
    protMode = 0; cplLevel = 3;
    regWrite(0, 32'h0000_7777);
    regRead(0, 32'h0000_7777, "R7 real mode allowed");

    curTag = "R8";
    regWrite(5, 32'h0);
    regWrite(4, 32'h0000_0400);
    regWrite(0, 32'h0000_9999);
    chk("R8 guard fault request", {31'b0, dbgReq}, 1);
    regRead(4, 32'h0, "R8 guarded read returns zero");
    handlerEntry = 1; tick(); idle();
    regRead(0, 32'h0000_7777, "R8 guarded write blocked");
    regRead(5, 32'h0000_0100, "R8 guard status bit");
    regRead(4, 32'h0, "R8 guard self-cleared");

    curTag = "R9";
    singleStep = 1; tick(); idle();
    chk("R9 step request", {31'b0, dbgReq}, 1);
    tick();
    chk("R12 one-cycle pulse", {31'b0, dbgReq}, 0);
    regRead(5, 32'h0000_0300, "R9 step status");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule